// File: doc/BRIEF.md
# Gated Configuration Register Window

This block sits on the host side of a disk interface and watches the host port that normally reaches the drive's task-file registers. The same eight offsets also reach a small set of timing and control registers that belong to the interface. Those registers stay hidden until the host performs a fixed access sequence. A sequence detector follows every host access. When the full sequence has been seen, the configuration window opens. While the window is open, accesses go to the internal register file and not to the drive. A closing write locks the window again.

Each host access lasts one cycle. It is a read or a write strobe with an offset, a size flag (16-bit or byte) and write data. The routing decision and any read data are combinational on the access cycle. State changes take effect at the following clock edge. The read-timing and write-timing registers exist in two banks. Bank selection is allowed only after a snooped enable write that the host issues while the window is locked.

Top module: `cfgwin_top`

## Requirements
- R1: After reset the window is closed (`win_open`=0), the detector is idle, and every access asserts `pass_thru` and leaves `cfg_hit` low.
- R2: The window opens at the clock edge after this exact sequence of consecutive accesses: a 16-bit read (`host_wide`=1) at offset 1, a second 16-bit read at offset 1, then a byte write (`host_wide`=0) of 0x03 at offset 2.
- R3: An access that does not fit the next step of the sequence sends the detector back to idle, and the whole sequence must then be repeated. A byte read of offset 1, a write to offset 1, and a key write of any value other than 0x03 are all breaking accesses. Idle cycles (no strobe) do not break the sequence.
- R4: While the window is closed, every access has `pass_thru`=1, `cfg_hit`=0 and `cfg_rdata`=0, and no internal register changes.
- R5: While the window is open, any number of accesses have `cfg_hit`=1 and `pass_thru`=0. A write at offset 0 (read timing), 1 (write timing), 3 (control) or 6 (miscellaneous) stores the low 8 data bits. A read at that offset returns the stored value on the same cycle.
- R6: While the window is open, a byte write of 0x83 at offset 2 closes it at the next edge. Other writes at offset 2, including a 16-bit write of 0x83, leave it open.
- R7: Offset 5 reads the version constant (0 by default) and ignores writes. Offsets 2, 4 and 7 read as 0. `cfg_rdata` is 0 on any cycle that is not an open-window read.
- R8: The timing registers at offsets 0 and 1 have two banks each. A byte or word write of 0xC0 to offset 3 while the window is locked sets a sticky bank enable; that write still passes through. When the enable is set, bit 0 of the miscellaneous register selects the bank. When it is clear, bank 0 is always used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd | input | 1 | Read strobe for one access cycle |
| host_wr | input | 1 | Write strobe for one access cycle |
| host_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| host_addr | input | 3 | Register offset 0..7 |
| host_wdata | input | 8 | Write data (low byte) |
| pass_thru | output | 1 | Current access goes to the drive |
| cfg_hit | output | 1 | Current access goes to the internal registers |
| cfg_rdata | output | 8 | Internal register read data for an open-window read |
| win_open | output | 1 | Configuration window is open |

## Verification
The detector is driven with the clean unlock triple and with near-miss versions of it. The near misses are a byte read in place of a 16-bit read, a wrong key value, a write between the two reads, and idle gaps inside the sequence. These cases separate a detector that checks size, offset and value at every step from one that checks only some of them. The close is tested with the right value at the wrong size, a wrong value, and the correct write. The bank tests compare writes before and after the snooped enable, which shows whether the enable is honoured. Random mixed traffic with a bias toward the key values then runs against a bench reference model of the sequence state, the registers and the bank enable.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ARM1 = 2'd1,
    SEQ_ARM2 = 2'd2,
    SEQ_OPEN = 2'd3
  } seq_state_e;

  localparam logic [ADDR_W-1:0] OFF_ARM   = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_KEY   = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_RTIM  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_WTIM  = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_STRAP = 3'd5;
  localparam logic [ADDR_W-1:0] OFF_MISC  = 3'd6;

  localparam logic [DATA_W-1:0] KEY_OPEN  = 8'h03;
  localparam logic [DATA_W-1:0] KEY_CLOSE = 8'h83;
  localparam logic [DATA_W-1:0] BANK_EN_V = 8'hC0;
endpackage

// File: rtl/cfgwin_seq.sv
module cfgwin_seq
  import cfgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic              acc_wide,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              open
);
  seq_state_e state_q, state_d;
  logic acc, is_arm, is_key, is_close;

  assign acc      = acc_rd | acc_wr;
  assign is_arm   = acc_rd & ~acc_wr & acc_wide & (acc_addr == OFF_ARM);
  assign is_key   = acc_wr & ~acc_wide & (acc_addr == OFF_KEY) & (acc_wdata == KEY_OPEN);
  assign is_close = acc_wr & ~acc_wide & (acc_addr == OFF_KEY) & (acc_wdata == KEY_CLOSE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (acc) state_d = is_arm ? SEQ_ARM1 : SEQ_IDLE;
      SEQ_ARM1: if (acc) state_d = is_arm ? SEQ_ARM2 : SEQ_IDLE;
      SEQ_ARM2: if (acc) state_d = is_key ? SEQ_OPEN : SEQ_IDLE;
      SEQ_OPEN: if (is_close) state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign open = (state_q == SEQ_OPEN);

  AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(acc_wr && !acc_wide && acc_addr == OFF_KEY && acc_wdata == KEY_OPEN)); // R2
  AST_BREAK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_ARM1 && acc && !is_arm) |=> (state_q == SEQ_IDLE)); // R3
  AST_CLOSE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (open && is_close) |=> !open); // R6
endmodule

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
  import cfgwin_pkg::*;
#(
  parameter int NBANK = 2,
  parameter logic [DATA_W-1:0] STRAP_VER = '0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              snoop_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic [DATA_W-1:0] rtim_q [NBANK];
  logic [DATA_W-1:0] wtim_q [NBANK];
  logic [DATA_W-1:0] ctrl_q, misc_q;
  logic              bank_en_q;
  logic [BSEL_W-1:0] bank_idx;
  logic              ctrl_en, misc_en, bank_set;

  assign bank_idx = bank_en_q ? misc_q[BSEL_W-1:0] : '0;
  assign ctrl_en  = wr_en & (addr == OFF_CTRL);
  assign misc_en  = wr_en & (addr == OFF_MISC);
  assign bank_set = snoop_wr & (addr == OFF_CTRL) & (wdata == BANK_EN_V);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic rt_en, wt_en;
    assign rt_en = wr_en & (addr == OFF_RTIM) & (bank_idx == BSEL_W'(b));
    assign wt_en = wr_en & (addr == OFF_WTIM) & (bank_idx == BSEL_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rtim_q[b] <= '0;
        wtim_q[b] <= '0;
      end else begin
        if (rt_en) rtim_q[b] <= wdata;
        if (wt_en) wtim_q[b] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      misc_q    <= '0;
      bank_en_q <= 1'b0;
    end else begin
      if (ctrl_en)  ctrl_q    <= wdata;
      if (misc_en)  misc_q    <= wdata;
      if (bank_set) bank_en_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (addr)
      OFF_RTIM:  rdata = rtim_q[bank_idx];
      OFF_WTIM:  rdata = wtim_q[bank_idx];
      OFF_CTRL:  rdata = ctrl_q;
      OFF_STRAP: rdata = STRAP_VER;
      OFF_MISC:  rdata = misc_q;
      default:   rdata = '0;
    endcase
  end

  AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ctrl_q) && $stable(misc_q))); // R4
  AST_BANK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bank_en_q |=> bank_en_q); // R8
endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
  import cfgwin_pkg::*;
#(
  parameter int NBANK = 2,
  parameter logic [DATA_W-1:0] STRAP_VER = '0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_wide,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              pass_thru,
  output logic              cfg_hit,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              win_open
);
  logic              acc;
  logic [DATA_W-1:0] reg_rdata;

  cfgwin_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_rd    (host_rd),
    .acc_wr    (host_wr),
    .acc_wide  (host_wide),
    .acc_addr  (host_addr),
    .acc_wdata (host_wdata),
    .open      (win_open)
  );

  assign acc       = host_rd | host_wr;
  assign cfg_hit   = acc & win_open;
  assign pass_thru = acc & ~win_open;

  cfgwin_regs #(.NBANK(NBANK), .STRAP_VER(STRAP_VER)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_hit & host_wr),
    .snoop_wr (pass_thru & host_wr),
    .addr     (host_addr),
    .wdata    (host_wdata),
    .rdata    (reg_rdata)
  );

  assign cfg_rdata = (cfg_hit & host_rd & ~host_wr) ? reg_rdata : '0;

  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_thru && cfg_hit)); // R4
  AST_LOCKED_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |-> (cfg_rdata == '0)); // R7
  AST_RESET_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !win_open); // R1
endmodule

// File: tb/cfgwin_top_tb_top.sv
module cfgwin_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_rd, host_wr, host_wide;
  logic [2:0] host_addr;
  logic [7:0] host_wdata;
  logic       pass_thru, cfg_hit, win_open;
  logic [7:0] cfg_rdata;

  int n_vec = 0;
  int n_bad = 0;

  int         m_state;
  logic [7:0] m_rt [2];
  logic [7:0] m_wt [2];
  logic [7:0] m_ctrl, m_misc;
  logic       m_ben;

  always #2.5 clk = ~clk;

  cfgwin_top dut_i (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_wide(host_wide), .host_addr(host_addr), .host_wdata(host_wdata),
    .pass_thru(pass_thru), .cfg_hit(cfg_hit), .cfg_rdata(cfg_rdata),
    .win_open(win_open)
  );

  function automatic logic [7:0] exp_rdata(input logic [2:0] a);
    int bk;
    bk = m_ben ? int'(m_misc[0]) : 0;
    case (a)
      3'd0: return m_rt[bk];
      3'd1: return m_wt[bk];
      3'd3: return m_ctrl;
      3'd6: return m_misc;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int next_state(input logic rd, input logic wr, input logic wide,
                                    input logic [2:0] a, input logic [7:0] d);
    logic arm, key, cls;
    arm = rd && !wr && wide && a == 3'd1;
    key = wr && !wide && a == 3'd2 && d == 8'h03;
    cls = wr && !wide && a == 3'd2 && d == 8'h83;
    if (m_state == 3) return cls ? 0 : 3;
    if (!(rd || wr)) return m_state;
    if (m_state == 0) return arm ? 1 : 0;
    if (m_state == 1) return arm ? 2 : 0;
    return key ? 3 : 0;
  endfunction

  task automatic model_reset();
    m_state = 0;
    m_rt[0] = 0; m_rt[1] = 0; m_wt[0] = 0; m_wt[1] = 0;
    m_ctrl = 0; m_misc = 0; m_ben = 0;
  endtask

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {open,pass,hit,rdata} actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input string req, input logic rd, input logic wr, input logic wide,
                     input logic [2:0] a, input logic [7:0] d);
    logic       e_open, e_pass, e_hit;
    logic [7:0] e_rd;
    int         bk;
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_wide = wide; host_addr = a; host_wdata = d;
    #1;
    e_open = (m_state == 3);
    e_pass = (rd || wr) && !e_open;
    e_hit  = (rd || wr) && e_open;
    e_rd   = (e_hit && rd && !wr) ? exp_rdata(a) : 8'h00;
    chk(req, {1'b0, win_open, pass_thru, cfg_hit, cfg_rdata},
             {1'b0, e_open, e_pass, e_hit, e_rd});
    bk = m_ben ? int'(m_misc[0]) : 0;
    if (e_hit && wr) begin
      case (a)
        3'd0: m_rt[bk] = d;
        3'd1: m_wt[bk] = d;
        3'd3: m_ctrl = d;
        3'd6: m_misc = d;
        default: ;
      endcase
    end
    if (e_pass && wr && a == 3'd3 && d == 8'hC0) m_ben = 1'b1;
    m_state = next_state(rd, wr, wide, a, d);
  endtask

  task automatic idle(input string req);
    acc(req, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic unlock(input string req);
    acc(req, 1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    acc(req, 1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    acc(req, 1'b0, 1'b1, 1'b0, 3'd2, 8'h03);
  endtask

  task automatic lock(input string req);
    acc(req, 1'b0, 1'b1, 1'b0, 3'd2, 8'h83);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    host_rd = 0; host_wr = 0; host_wide = 0; host_addr = 0; host_wdata = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    idle("R1");
    acc("R1", 1'b1, 1'b0, 1'b0, 3'd0, 8'h00);

    // R4: locked writes pass through and leave registers untouched
    acc("R4", 1'b0, 1'b1, 1'b0, 3'd0, 8'hA5);
    acc("R4", 1'b0, 1'b1, 1'b1, 3'd6, 8'h3C);
    acc("R4", 1'b1, 1'b0, 1'b0, 3'd3, 8'h00);

    // R2: clean unlock, window opens; registers still at reset
    unlock("R2");
    acc("R2", 1'b1, 1'b0, 1'b0, 3'd0, 8'h00);
    acc("R4", 1'b1, 1'b0, 1'b0, 3'd6, 8'h00);

    // R5: several accesses inside one window
    acc("R5", 1'b0, 1'b1, 1'b0, 3'd0, 8'h21);
    acc("R5", 1'b0, 1'b1, 1'b1, 3'd1, 8'h32);
    acc("R5", 1'b0, 1'b1, 1'b0, 3'd3, 8'h85);
    acc("R5", 1'b1, 1'b0, 1'b0, 3'd0, 8'h00);
    acc("R5", 1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    acc("R5", 1'b1, 1'b0, 1'b0, 3'd3, 8'h00);

    // R7: strap version, read-only, unimplemented offsets
    acc("R7", 1'b0, 1'b1, 1'b0, 3'd5, 8'hFF);
    acc("R7", 1'b1, 1'b0, 1'b0, 3'd5, 8'h00);
    acc("R7", 1'b0, 1'b1, 1'b0, 3'd4, 8'h77);
    acc("R7", 1'b1, 1'b0, 1'b0, 3'd4, 8'h00);
    acc("R7", 1'b1, 1'b0, 1'b0, 3'd7, 8'h00);

    // R6: near-miss closes keep window open, real close locks
    acc("R6", 1'b0, 1'b1, 1'b1, 3'd2, 8'h83);
    acc("R6", 1'b0, 1'b1, 1'b0, 3'd2, 8'h84);
    acc("R6", 1'b1, 1'b0, 1'b0, 3'd2, 8'h00);
    lock("R6");
    acc("R6", 1'b1, 1'b0, 1'b0, 3'd0, 8'h00);

    // R3: broken sequences
    acc("R3", 1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    acc("R3", 1'b1, 1'b0, 1'b0, 3'd1, 8'h00);
    acc("R3", 1'b0, 1'b1, 1'b0, 3'd2, 8'h03);
    idle("R3");
    acc("R3", 1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    acc("R3", 1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    acc("R3", 1'b0, 1'b1, 1'b0, 3'd2, 8'h04);
    idle("R3");
    acc("R3", 1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    acc("R3", 1'b0, 1'b1, 1'b1, 3'd1, 8'h00);
    acc("R3", 1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    acc("R3", 1'b0, 1'b1, 1'b0, 3'd2, 8'h03);
    idle("R3");
    // idle gaps do not break the sequence
    acc("R3", 1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    idle("R3");
    acc("R3", 1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    idle("R3");
    acc("R3", 1'b0, 1'b1, 1'b0, 3'd2, 8'h03);
    acc("R3", 1'b1, 1'b0, 1'b0, 3'd0, 8'h00);

    // R8: bank select ignored until enable snooped while locked
    acc("R8", 1'b0, 1'b1, 1'b0, 3'd6, 8'h01);
    acc("R8", 1'b0, 1'b1, 1'b0, 3'd0, 8'h55);
    acc("R8", 1'b0, 1'b1, 1'b0, 3'd3, 8'hC0);
    acc("R8", 1'b0, 1'b1, 1'b0, 3'd6, 8'h00);
    acc("R8", 1'b1, 1'b0, 1'b0, 3'd0, 8'h00);
    lock("R8");
    acc("R8", 1'b0, 1'b1, 1'b0, 3'd3, 8'hC0);
    unlock("R8");
    acc("R8", 1'b0, 1'b1, 1'b0, 3'd6, 8'h01);
    acc("R8", 1'b0, 1'b1, 1'b0, 3'd0, 8'h66);
    acc("R8", 1'b0, 1'b1, 1'b0, 3'd1, 8'h77);
    acc("R8", 1'b1, 1'b0, 1'b0, 3'd0, 8'h00);
    acc("R8", 1'b0, 1'b1, 1'b0, 3'd6, 8'h00);
    acc("R8", 1'b1, 1'b0, 1'b0, 3'd0, 8'h00);
    acc("R8", 1'b1, 1'b0, 1'b0, 3'd1, 8'h00);
    lock("R8");

    // constrained random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int         r;
      logic [7:0] d;
      r = int'($urandom_range(0, 19));
      if (r < 2) unlock("RND");
      else if (r == 2) lock("RND");
      else begin
        case ($urandom_range(0, 3))
          0: d = 8'h03;
          1: d = 8'h83;
          2: d = 8'hC0;
          default: d = 8'($urandom);
        endcase
        case ($urandom_range(0, 2))
          0: acc("RND", 1'b1, 1'b0, 1'($urandom), 3'($urandom), d);
          1: acc("RND", 1'b0, 1'b1, 1'($urandom), 3'($urandom), d);
          default: idle("RND");
        endcase
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule